// File: doc/BRIEF.md
# DRAM Write-Leveling Command Sequencer

This block drives the command side of a write-leveling pass on a single DRAM rank. A one-cycle start request latches a rank, a bank, a 16-bit mode-register image and four latency figures. The block then plays four commands onto a command bus. Each command is held for exactly one clock. Each command is followed by its own quiet interval, during which the bus shows the idle code.

The four commands always come in the same order:
1. A mode-register-set carrying the supplied image, which turns leveling on for the rank.
2. A no-operation tagged as a write.
3. A no-operation in its alternate encoding, tagged as a read.
4. A second mode-register-set carrying the same image with bit 12 forced high, which turns leveling off.

After the last quiet interval a one-cycle done pulse tells the surrounding training logic that the rank can be sampled or adjusted. Sampling the data feedback and moving delay lines are left to other blocks.

Top module: `wlvl_cmd_seq`

## Requirements
- R1: After reset, cmd_o is idle (code 0), busy_o is 0 and done_o is 0.
- R2: Command codes are idle=0, mode-register-set=1, no-operation=2 and alternate no-operation=3. The four commands appear in the order 1, 2, 3, 1, and each is driven for exactly one clock. A start sampled at a clock edge puts the first command on the bus in the cycle right after that edge.
- R3: The first command carries addr_o = mr_i, bank_o = bank_i, rowbits_o = 6 and dir_o = none (0). The next command follows 41 cycles later, which leaves 40 idle cycles between them.
- R4: The second command carries addr_o = 8, bank_o = 0, rowbits_o = 0 and dir_o = write (1). The next command follows cwl_i + wlo_i + 1 cycles later.
- R5: The third command carries addr_o = 4, bank_o = 0, rowbits_o = 0 and dir_o = read (2). The next command follows cas_i + 38 + 1 cycles later.
- R6: The fourth command carries addr_o = mr_i with bit 12 set, bank_o = bank_i, rowbits_o = 6 and dir_o = none.
- R7: done_o is high for exactly one cycle, tmod_i + 1 cycles after the fourth command. Any wait of zero gives back-to-back cycles.
- R8: A start request is ignored while busy_o is high. No extra commands appear, and the running sequence keeps its original values.
- R9: The latency, mode, bank and rank inputs are sampled only when a start is accepted. Changing them mid-sequence has no effect.
- R10: Every command drives rank_o = the captured rank and rsel_ap_o = 1. Between commands cmd_o is idle, so exactly four non-idle cycles occur per sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, taken only when idle |
| rank_i | input | 2 | Target rank |
| bank_i | input | 3 | Bank for the mode-register commands |
| mr_i | input | 16 | Mode-register image that enables leveling |
| cwl_i | input | 5 | CAS write latency in cycles |
| wlo_i | input | 5 | Write-leveling output delay in cycles |
| cas_i | input | 5 | CAS latency in cycles |
| tmod_i | input | 5 | Mode-register-set-to-command delay in cycles |
| cmd_o | output | 2 | Command code |
| bank_o | output | 3 | Command bank |
| addr_o | output | 16 | Command address |
| rank_o | output | 2 | Command rank |
| rowbits_o | output | 3 | Number of row-address bits used by the command |
| dir_o | output | 2 | Data-direction tag (0 none, 1 write, 2 read) |
| rsel_ap_o | output | 1 | Rank-select / auto-precharge control bit, 1 on every command |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A wrong step index shows up at the ports in one of two ways. The next command may carry the wrong code, address, bank or direction tag. Or the sequence may produce too many or too few non-idle cycles. Either shows at the very next command edge, at most about 70 cycles later. A corrupted wait count moves the arrival cycle of the following command or of the done pulse. Checking every command's cycle number against the latency arithmetic therefore exposes it within one step. Zero-latency and maximum-latency runs cover the back-to-back and widest-counter cases. A start pulse mid-run with changed inputs shows whether the captured values leak.

// File: rtl/wl_seq_pkg.sv
package wl_seq_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE    = 2'd0,
        CMD_MRS     = 2'd1,
        CMD_NOP     = 2'd2,
        CMD_NOP_ALT = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_WR   = 2'd1,
        DIR_RD   = 2'd2
    } dir_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } state_e;

    localparam int STEP_N       = 4;
    localparam int STEP_W       = $clog2(STEP_N);
    localparam int ROWBITS_W    = 3;
    localparam int MRS_ROWBITS  = 6;

    typedef struct packed {
        cmd_e                  cmd;
        dir_e                  dir;
        logic [ROWBITS_W-1:0]  rowbits;
        logic                  use_mr;   // address/bank taken from captured mode image
        logic                  set_dis;  // force the leveling-off bit
    } step_ctl_t;

    function automatic step_ctl_t step_ctl(input logic [STEP_W-1:0] idx);
        step_ctl_t c;
        c = '{cmd: CMD_IDLE, dir: DIR_NONE, rowbits: '0, use_mr: 1'b0, set_dis: 1'b0};
        case (idx)
            2'd0: c = '{cmd: CMD_MRS, dir: DIR_NONE,
                        rowbits: ROWBITS_W'(MRS_ROWBITS), use_mr: 1'b1, set_dis: 1'b0};
            2'd1: c = '{cmd: CMD_NOP, dir: DIR_WR,
                        rowbits: '0, use_mr: 1'b0, set_dis: 1'b0};
            2'd2: c = '{cmd: CMD_NOP_ALT, dir: DIR_RD,
                        rowbits: '0, use_mr: 1'b0, set_dis: 1'b0};
            default: c = '{cmd: CMD_MRS, dir: DIR_NONE,
                        rowbits: ROWBITS_W'(MRS_ROWBITS), use_mr: 1'b1, set_dis: 1'b1};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/wl_step_rom.sv
module wl_step_rom
    import wl_seq_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int BANK_W  = 3,
    parameter int LAT_W   = 5,
    parameter int WAIT_W  = 7,
    parameter int WLMRD   = 40,
    parameter int RD_PAD  = 38,
    parameter int DIS_BIT = 12,
    parameter int WR_ADDR = 8,
    parameter int RD_ADDR = 4
) (
    input  logic [STEP_W-1:0]    step_i,
    input  logic [ADDR_W-1:0]    mr_i,
    input  logic [BANK_W-1:0]    bank_i,
    input  logic [LAT_W-1:0]     cwl_i,
    input  logic [LAT_W-1:0]     wlo_i,
    input  logic [LAT_W-1:0]     cas_i,
    input  logic [LAT_W-1:0]     tmod_i,
    output cmd_e                 cmd_o,
    output dir_e                 dir_o,
    output logic [ROWBITS_W-1:0] rowbits_o,
    output logic [ADDR_W-1:0]    addr_o,
    output logic [BANK_W-1:0]    bank_o,
    output logic [WAIT_W-1:0]    wait_o
);
    localparam logic [ADDR_W-1:0] DIS_MASK = ADDR_W'(1) << DIS_BIT;

    step_ctl_t ctl;

    always_comb begin
        ctl       = step_ctl(step_i);
        cmd_o     = ctl.cmd;
        dir_o     = ctl.dir;
        rowbits_o = ctl.rowbits;
        if (ctl.use_mr) begin
            addr_o = ctl.set_dis ? (mr_i | DIS_MASK) : mr_i;
            bank_o = bank_i;
        end else begin
            addr_o = (ctl.dir == DIR_WR) ? ADDR_W'(WR_ADDR) : ADDR_W'(RD_ADDR);
            bank_o = '0;
        end
        case (step_i)
            2'd0:    wait_o = WAIT_W'(WLMRD);
            2'd1:    wait_o = WAIT_W'(cwl_i) + WAIT_W'(wlo_i);
            2'd2:    wait_o = WAIT_W'(cas_i) + WAIT_W'(RD_PAD);
            default: wait_o = WAIT_W'(tmod_i);
        endcase
    end

endmodule

// File: rtl/wl_wait_ctr.sv
module wl_wait_ctr #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic [W-1:0] cnt_o,
    output logic         last_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign cnt_o  = cnt_q;
    assign last_o = (cnt_q == W'(1));

endmodule

// File: rtl/wlvl_cmd_seq.sv
module wlvl_cmd_seq
    import wl_seq_pkg::*;
#(
    parameter int RANK_W  = 2,
    parameter int BANK_W  = 3,
    parameter int ADDR_W  = 16,
    parameter int LAT_W   = 5,
    parameter int WLMRD   = 40,
    parameter int RD_PAD  = 38,
    parameter int DIS_BIT = 12,
    parameter int WR_ADDR = 8,
    parameter int RD_ADDR = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [RANK_W-1:0] rank_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [ADDR_W-1:0] mr_i,
    input  logic [LAT_W-1:0]  cwl_i,
    input  logic [LAT_W-1:0]  wlo_i,
    input  logic [LAT_W-1:0]  cas_i,
    input  logic [LAT_W-1:0]  tmod_i,
    output logic [1:0]        cmd_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [RANK_W-1:0] rank_o,
    output logic [2:0]        rowbits_o,
    output logic [1:0]        dir_o,
    output logic              rsel_ap_o,
    output logic              busy_o,
    output logic              done_o
);
    // two extra bits hold the sum of two latencies and a pad up to 2^LAT_W
    localparam int WAIT_W   = LAT_W + 2;
    localparam int LAST_STP = STEP_N - 1;

    state_e              state_q;
    logic [STEP_W-1:0]   step_q;
    logic [RANK_W-1:0]   rank_q;
    logic [BANK_W-1:0]   bank_q;
    logic [ADDR_W-1:0]   mr_q;
    logic [LAT_W-1:0]    cwl_q, wlo_q, cas_q, tmod_q;

    cmd_e                rom_cmd;
    dir_e                rom_dir;
    logic [ROWBITS_W-1:0] rom_rowbits;
    logic [ADDR_W-1:0]   rom_addr;
    logic [BANK_W-1:0]   rom_bank;
    logic [WAIT_W-1:0]   rom_wait;
    logic [WAIT_W-1:0]   cnt;
    logic                cnt_last;
    logic                issuing;

    assign issuing = (state_q == ST_ISSUE);

    wl_step_rom #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .LAT_W(LAT_W), .WAIT_W(WAIT_W),
        .WLMRD(WLMRD), .RD_PAD(RD_PAD), .DIS_BIT(DIS_BIT),
        .WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR)
    ) u_rom (
        .step_i(step_q), .mr_i(mr_q), .bank_i(bank_q),
        .cwl_i(cwl_q), .wlo_i(wlo_q), .cas_i(cas_q), .tmod_i(tmod_q),
        .cmd_o(rom_cmd), .dir_o(rom_dir), .rowbits_o(rom_rowbits),
        .addr_o(rom_addr), .bank_o(rom_bank), .wait_o(rom_wait)
    );

    wl_wait_ctr #(.W(WAIT_W)) u_wait (
        .clk(clk), .rst(rst), .load_i(issuing), .val_i(rom_wait),
        .cnt_o(cnt), .last_o(cnt_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            rank_q  <= '0;
            bank_q  <= '0;
            mr_q    <= '0;
            cwl_q   <= '0;
            wlo_q   <= '0;
            cas_q   <= '0;
            tmod_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        rank_q  <= rank_i;
                        bank_q  <= bank_i;
                        mr_q    <= mr_i;
                        cwl_q   <= cwl_i;
                        wlo_q   <= wlo_i;
                        cas_q   <= cas_i;
                        tmod_q  <= tmod_i;
                        step_q  <= '0;
                        state_q <= ST_ISSUE;
                    end
                end
                ST_ISSUE, ST_WAIT: begin
                    if ((issuing && rom_wait == '0) || (!issuing && cnt_last)) begin
                        if (step_q == STEP_W'(LAST_STP)) begin
                            state_q <= ST_DONE;
                        end else begin
                            step_q  <= step_q + STEP_W'(1);
                            state_q <= ST_ISSUE;
                        end
                    end else if (issuing) begin
                        state_q <= ST_WAIT;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd_o     = issuing ? rom_cmd     : CMD_IDLE;
        dir_o     = issuing ? rom_dir     : DIR_NONE;
        rowbits_o = issuing ? rom_rowbits : '0;
        addr_o    = issuing ? rom_addr    : '0;
        bank_o    = issuing ? rom_bank    : '0;
        rsel_ap_o = issuing;
        rank_o    = rank_q;
        busy_o    = (state_q != ST_IDLE);
        done_o    = (state_q == ST_DONE);
    end

    // R2: consecutive commands never repeat the same code, so no command stretches past one clock
    p_single_cycle_cmd_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_o != CMD_IDLE) |=> (cmd_o != $past(cmd_o)));

    // R7: a waiting state always has time left on the counter
    p_wait_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT) |-> (cnt != '0));

    // R7: completion is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8: a start during a running sequence leaves captured values untouched
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> ($stable(mr_q) && $stable(cas_q) && $stable(rank_q)));

    // R6: the closing mode-register command carries the leveling-off bit
    p_disable_bit_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_MRS && step_q == STEP_W'(LAST_STP)) |-> addr_o[DIS_BIT]);

    // R10: an idle block keeps the bus quiet
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (cmd_o == CMD_IDLE && !rsel_ap_o));

endmodule

// File: tb/sim_wlvl_cmd_seq.sv
`timescale 1ns/1ps
module sim_wlvl_cmd_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [1:0]  rank_i;
    logic [2:0]  bank_i;
    logic [15:0] mr_i;
    logic [4:0]  cwl_i, wlo_i, cas_i, tmod_i;
    logic [1:0]  cmd_o;
    logic [2:0]  bank_o;
    logic [15:0] addr_o;
    logic [1:0]  rank_o;
    logic [2:0]  rowbits_o;
    logic [1:0]  dir_o;
    logic        rsel_ap_o, busy_o, done_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    wlvl_cmd_seq u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .rank_i(rank_i), .bank_i(bank_i),
        .mr_i(mr_i), .cwl_i(cwl_i), .wlo_i(wlo_i), .cas_i(cas_i), .tmod_i(tmod_i),
        .cmd_o(cmd_o), .bank_o(bank_o), .addr_o(addr_o), .rank_o(rank_o),
        .rowbits_o(rowbits_o), .dir_o(dir_o), .rsel_ap_o(rsel_ap_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // packed view: {cmd,dir,rowbits,rsel,bank,rank,addr}
    function automatic logic [28:0] pack(input logic [1:0] c, input logic [1:0] d,
            input logic [2:0] rb, input logic rs, input logic [2:0] b,
            input logic [1:0] r, input logic [15:0] a);
        return {c, d, rb, rs, b, r, a};
    endfunction

    task automatic run_seq(input string name, input logic [15:0] mr, input logic [2:0] bk,
                           input logic [1:0] rk, input int cwl, input int wlo,
                           input int cas, input int tmod, input bit perturb);
        logic [28:0] got [4];
        logic [28:0] exp [4];
        int at [4];
        int eat [4];
        int ncmd = 0;
        int ndone = 0;
        int done_at = -1;
        int edone;
        bit busy1 = 1'b0;
        bit busy_after = 1'b1;
        @(negedge clk);
        mr_i = mr; bank_i = bk; rank_i = rk;
        cwl_i = 5'(cwl); wlo_i = 5'(wlo); cas_i = 5'(cas); tmod_i = 5'(tmod);
        start_i = 1'b1;
        eat[0] = 1;
        eat[1] = eat[0] + 41;
        eat[2] = eat[1] + cwl + wlo + 1;
        eat[3] = eat[2] + cas + 38 + 1;
        edone  = eat[3] + tmod + 1;
        exp[0] = pack(2'd1, 2'd0, 3'd6, 1'b1, bk, rk, mr);
        exp[1] = pack(2'd2, 2'd1, 3'd0, 1'b1, 3'd0, rk, 16'd8);
        exp[2] = pack(2'd3, 2'd2, 3'd0, 1'b1, 3'd0, rk, 16'd4);
        exp[3] = pack(2'd1, 2'd0, 3'd6, 1'b1, bk, rk, mr | 16'h1000);
        for (int cyc = 1; cyc < 400; cyc++) begin
            @(negedge clk);
            if (cyc == 1) busy1 = busy_o;
            if (cmd_o != 2'd0) begin
                if (ncmd < 4) begin
                    got[ncmd] = pack(cmd_o, dir_o, rowbits_o, rsel_ap_o, bank_o, rank_o, addr_o);
                    at[ncmd]  = cyc;
                end
                ncmd++;
            end
            if (done_o) begin
                ndone++;
                if (done_at < 0) done_at = cyc;
            end
            if (done_at >= 0 && cyc == done_at + 1) busy_after = busy_o;
            // drive after sampling
            start_i = 1'b0;
            if (perturb && cyc == 10) begin
                start_i = 1'b1;
                mr_i = ~mr; bank_i = ~bk; rank_i = ~rk;
            end
            if (perturb && cyc == 12) begin
                cwl_i = 5'(cwl + 3); wlo_i = 5'(wlo + 2);
                cas_i = 5'(cas + 5); tmod_i = 5'(tmod + 4);
            end
            if (done_at >= 0 && cyc >= done_at + 3) break;
        end
        chk(busy1, "R2", {name, " busy after start"}, 32'(busy1), 32'd1);
        chk(ncmd == 4, "R10", {name, " non-idle cycle count"}, 32'(ncmd), 32'd4);
        for (int i = 0; i < 4; i++) begin
            if (i < ncmd) begin
                chk(got[i] == exp[i], (i == 0) ? "R3" : (i == 1) ? "R4" : (i == 2) ? "R5" : "R6",
                    $sformatf("%s fields of command %0d", name, i), 32'(got[i]), 32'(exp[i]));
                chk(at[i] == eat[i], (i == 0) ? "R2" : (i == 1) ? "R3" : (i == 2) ? "R4" : "R5",
                    $sformatf("%s cycle of command %0d", name, i), 32'(at[i]), 32'(eat[i]));
            end
        end
        chk(done_at == edone, "R7", {name, " done cycle"}, 32'(done_at), 32'(edone));
        chk(ndone == 1, "R7", {name, " done pulse count"}, 32'(ndone), 32'd1);
        chk(!busy_after, "R7", {name, " idle after done"}, 32'(busy_after), 32'd0);
        if (perturb)
            chk(ncmd == 4 && done_at == edone, "R8",
                {name, " mid-run start and R9 input change ignored"}, 32'(done_at), 32'(edone));
    endtask

    task automatic test_reset;
        chk(cmd_o == 2'd0 && !busy_o && !done_o, "R1", "reset state",
            {27'd0, cmd_o, busy_o, done_o}, 32'd0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
                $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1; start_i = 1'b0; rank_i = '0; bank_i = '0; mr_i = '0;
        cwl_i = '0; wlo_i = '0; cas_i = '0; tmod_i = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        run_seq("typical", 16'h0046, 3'd1, 2'd2, 5, 7, 6, 12, 1'b0);
        run_seq("zero-wait", 16'h0004, 3'd2, 2'd0, 0, 0, 0, 0, 1'b0);
        run_seq("max-latency", 16'hFFFF, 3'd7, 2'd3, 31, 31, 31, 31, 1'b0);
        run_seq("busy-restart", 16'h0A44, 3'd5, 2'd1, 9, 4, 11, 6, 1'b1);
        run_seq("back-to-back", 16'h0000, 3'd0, 2'd1, 1, 2, 3, 1, 1'b0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule